// File: doc/BRIEF.md
# Multi-Palette Port Decoder

This block sits on an 8-bit, I/O-mapped peripheral bus and decodes a 27-port window starting at 0x300. Inside the window are three independent colour-palette groups. Each works like a classic VGA DAC and has a write index, a read index, a colour sub-index for each path, a pixel mask and a 256-entry RGB table. Two further ports act as write-only strobes. A write to one of them raises a clock-divider enable flag, and a write to the other lowers it. The data byte on a strobe write does not matter.

Downstream video logic reads the divider enable and the three pixel masks directly. It reads stored colours through a combinational lookup port: it supplies a group number and a pixel index, and the block ANDs the group's pixel mask onto the index before it fetches the colour. Bus reads return palette bytes from the data port, one cycle after the read strobe. Every other read returns 0xFF.

Top module: `pal_port_decoder`

## Requirements
- R1: After a synchronous active-low reset, `div_en` is 0 and every pixel mask is 0x00. Every colour entry of every group reads back as 0x000000, and `bus_rdata` is 0xFF.
- R2: The palette groups decode at 0x300, 0x308 and 0x310 (group 0, 1, 2). Within a group, offset +0 loads the write index, +1 is the colour data port, +2 loads the pixel mask and +3 loads the read index.
- R3: Data-port writes fill an entry in the order red, green, blue. After the third byte, the write index advances by one and the write sub-index returns to 0. A stored entry appears on `lk_rgb` as {red[23:16], green[15:8], blue[7:0]}.
- R4: The write index wraps from 255 to 0 when an entry completes.
- R5: A write to the write-index port aborts any partial triplet on the write path and restarts at red. A write to the read-index port does the same for the read path.
- R6: Any write to 0x31A sets `div_en` and any write to 0x319 clears it, whatever the data byte. The new value shows on the cycle after the write strobe.
- R7: A read strobe on a data port (0x301, 0x309, 0x311) puts the byte at that group's read index and read sub-index on `bus_rdata` in the cycle after the strobe. The read path then advances with the same red, green, blue rule, and the read index wraps from 255 to 0.
- R8: A read strobe on any other address, inside or outside the window, puts 0xFF on `bus_rdata` in the next cycle. `bus_rdata` holds its value between read strobes.
- R9: Writes to 0x304–0x307, 0x30C–0x30F, 0x314–0x318 and to addresses outside the window change no palette, mask, index or `div_en` state.
- R10: `lk_rgb` is combinational. It returns the colour of group `lk_grp` at index (`lk_idx` AND that group's mask). A group number of 3 returns 0x000000.
- R11: The three groups are independent. Writes to one group leave the entries, indices and mask of the other groups unchanged.
- R12: `pix_mask` carries group g's mask in bits [8g+7:8g]. A mask write shows there on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| div_en | output | 1 | Clock-divider enable flag |
| pix_mask | output | 24 | Pixel masks of groups 2,1,0 (8 bits each) |
| lk_grp | input | 2 | Lookup group number |
| lk_idx | input | 8 | Lookup pixel index |
| lk_rgb | output | 24 | Looked-up colour {R,G,B} |

## Verification
Register state updates on the clock edge that samples a write strobe, and read data on the edge that samples a read strobe. `div_en`, `pix_mask`, colour entries and `bus_rdata` are therefore all due one cycle after their stimulus, while `lk_rgb` follows its inputs in the same cycle. The bench drives each strobe for exactly one cycle starting at a falling edge and samples the result at the next falling edge, after the single register stage has taken the value. Lookups are sampled a short delay after the lookup inputs change, with no clock edge in between.

// File: rtl/palbus_pkg.sv
// palbus_pkg: shared field codes and helpers for the multi-palette port decoder.
// Assumes group strides are multiples of four, so the low two offset bits name
// the register inside a group.
package palbus_pkg;

    // Register selected by the low two offset bits within a group
    typedef enum logic [1:0] {
        FLD_WIDX  = 2'd0,
        FLD_DATA  = 2'd1,
        FLD_MASK  = 2'd2,
        FLD_RIDX  = 2'd3
    } fld_e;

    // Number of colour components in one palette entry
    localparam int unsigned COMPONENTS = 3;

    // Next colour sub-index: 0 -> 1 -> 2 -> 0
    function automatic logic [1:0] sub_next(input logic [1:0] s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction

endpackage

// File: rtl/palbus_decode.sv
// palbus_decode: turns a bus address into a one-hot palette-group hit, the
// register field inside the group and the two divider strobe hits.
// Assumes: BASE is aligned to STRIDE, STRIDE is a multiple of four, and the
// strobe offsets lie beyond the last group.
module palbus_decode
    import palbus_pkg::*;
#(
    parameter int unsigned AW      = 10,
    parameter int unsigned BASE    = 10'h300,
    parameter int unsigned GROUPS  = 3,
    parameter int unsigned STRIDE  = 8,
    parameter int unsigned WIN     = 27,
    parameter int unsigned ON_OFS  = 26,
    parameter int unsigned OFF_OFS = 25
) (
    input  logic [AW-1:0]     addr,
    output logic [GROUPS-1:0] grp_hit,
    output fld_e              fld,
    output logic              on_hit,
    output logic              off_hit
);

    localparam logic [AW-1:0] BASE_A = AW'(BASE);
    localparam logic [AW-1:0] WIN_A  = AW'(WIN);

    logic [AW-1:0] offs;
    logic          in_win;

    // Window membership and offset from the window base
    always_comb begin
        offs   = addr - BASE_A;
        in_win = (addr >= BASE_A) && (offs < WIN_A);
    end

    // Field code from the offset inside a group
    always_comb fld = fld_e'(offs[1:0]);

    // One comparator pair per group: first four ports of each stride
    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_hit
        localparam logic [AW-1:0] LO = AW'(g * STRIDE);
        localparam logic [AW-1:0] HI = AW'(g * STRIDE + 4);
        always_comb grp_hit[g] = in_win && (offs >= LO) && (offs < HI);
    end

    // Divider set and clear strobe ports
    always_comb begin
        on_hit  = in_win && (offs == AW'(ON_OFS));
        off_hit = in_win && (offs == AW'(OFF_OFS));
    end

endmodule

// File: rtl/palbus_group.sv
// palbus_group: one DAC-style palette. It holds the write and read indices,
// their own colour sub-indices, the pixel mask and the colour table. The
// write and read strobes arrive already qualified by this group's decode hit.
// Assumes ENTRIES is a power of two so a masked index always lands in range.
// Concurrent use of both paths is allowed but their interaction is undefined.
module palbus_group
    import palbus_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned ENTRIES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  fld_e                 fld,
    input  logic [DW-1:0]        wdat,
    input  logic [$clog2(ENTRIES)-1:0] lk_idx,
    output logic [DW-1:0]        rd_byte,
    output logic [DW-1:0]        mask_o,
    output logic [COMPONENTS*DW-1:0] lk_rgb
);

    localparam int unsigned IW = $clog2(ENTRIES);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [0:COMPONENTS-1][DW-1:0] table_q [ENTRIES];
    logic [IW-1:0] widx_q, ridx_q;
    logic [1:0]    wsub_q, rsub_q;
    logic [DW-1:0] mask_q;
    logic [IW-1:0] lk_eff;

    logic data_wr, data_rd;
    always_comb begin
        data_wr = wr_en && (fld == FLD_DATA);
        data_rd = rd_en && (fld == FLD_DATA);
    end

    // Write pointer: load on index write, step on each data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx_q <= '0;
            wsub_q <= 2'd0;
        end else if (wr_en && fld == FLD_WIDX) begin
            widx_q <= wdat[IW-1:0];
            wsub_q <= 2'd0;
        end else if (data_wr) begin
            wsub_q <= sub_next(wsub_q);
            if (wsub_q == 2'd2) widx_q <= (widx_q == LAST) ? '0 : widx_q + 1'b1;
        end
    end

    // Read pointer: load on index write, step on each data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx_q <= '0;
            rsub_q <= 2'd0;
        end else if (wr_en && fld == FLD_RIDX) begin
            ridx_q <= wdat[IW-1:0];
            rsub_q <= 2'd0;
        end else if (data_rd) begin
            rsub_q <= sub_next(rsub_q);
            if (rsub_q == 2'd2) ridx_q <= (ridx_q == LAST) ? '0 : ridx_q + 1'b1;
        end
    end

    // Pixel mask register
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= '0;
        else if (wr_en && fld == FLD_MASK) mask_q <= wdat;
    end

    // Colour table: cleared on reset, one byte written per data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) table_q[i] <= '0;
        end else if (data_wr) begin
            table_q[widx_q][wsub_q] <= wdat;
        end
    end

    // Byte under the read pointer and masked lookup
    always_comb begin
        rd_byte = table_q[ridx_q][rsub_q];
        lk_eff  = lk_idx & IW'(mask_q);
        lk_rgb  = table_q[lk_eff];
        mask_o  = mask_q;
    end

endmodule

// File: rtl/pal_port_decoder.sv
// pal_port_decoder: top of the multi-palette port block. It decodes the port
// window, drives the palette groups, keeps the divider enable flag, registers
// read data and muxes the lookup port. Bus strobes are single-cycle and
// qualified by bus_addr/bus_wdata in the same cycle.
module pal_port_decoder
    import palbus_pkg::*;
#(
    parameter int unsigned AW      = 10,
    parameter int unsigned DW      = 8,
    parameter int unsigned BASE    = 10'h300,
    parameter int unsigned GROUPS  = 3,
    parameter int unsigned STRIDE  = 8,
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned WIN     = 27,
    parameter int unsigned ON_OFS  = 26,
    parameter int unsigned OFF_OFS = 25,
    localparam int unsigned GW     = $clog2(GROUPS + 1),
    localparam int unsigned IW     = $clog2(ENTRIES),
    localparam int unsigned CW     = COMPONENTS * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DW-1:0]        bus_rdata,
    output logic                 div_en,
    output logic [GROUPS*DW-1:0] pix_mask,
    input  logic [GW-1:0]        lk_grp,
    input  logic [IW-1:0]        lk_idx,
    output logic [CW-1:0]        lk_rgb
);

    logic [GROUPS-1:0] grp_hit;
    fld_e              fld;
    logic              on_hit, off_hit;
    logic [DW-1:0]     grp_byte [GROUPS];
    logic [CW-1:0]     grp_rgb  [GROUPS];

    palbus_decode #(
        .AW(AW), .BASE(BASE), .GROUPS(GROUPS), .STRIDE(STRIDE),
        .WIN(WIN), .ON_OFS(ON_OFS), .OFF_OFS(OFF_OFS)
    ) u_dec (
        .addr(bus_addr), .grp_hit(grp_hit), .fld(fld),
        .on_hit(on_hit), .off_hit(off_hit)
    );

    // One palette instance per group
    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_pal
        palbus_group #(.DW(DW), .ENTRIES(ENTRIES)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_wr && grp_hit[g]),
            .rd_en(bus_rd && grp_hit[g]),
            .fld(fld), .wdat(bus_wdata), .lk_idx(lk_idx),
            .rd_byte(grp_byte[g]),
            .mask_o(pix_mask[g*DW +: DW]),
            .lk_rgb(grp_rgb[g])
        );
    end

    // Divider enable: set and clear strobes, data ignored
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_en <= 1'b0;
        else if (bus_wr && on_hit)  div_en <= 1'b1;
        else if (bus_wr && off_hit) div_en <= 1'b0;
    end

    // Read data: palette byte from a data port, 0xFF for anything else
    logic [DW-1:0] rd_next;
    always_comb begin
        rd_next = '1;
        for (int g = 0; g < int'(GROUPS); g++)
            if (grp_hit[g] && fld == FLD_DATA) rd_next = grp_byte[g];
    end

    // Read data register, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '1;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // Lookup mux; unknown group numbers return black
    always_comb begin
        lk_rgb = '0;
        for (int g = 0; g < int'(GROUPS); g++)
            if (lk_grp == GW'(g)) lk_rgb = grp_rgb[g];
    end

endmodule

// File: rtl/palbus_checker.sv
// palbus_checker: bus-level properties of pal_port_decoder, bound to it below.
// Assumes BASE and STRIDE keep the data port at low address bits 01.
module palbus_checker #(
    parameter int unsigned AW     = 10,
    parameter int unsigned DW     = 8,
    parameter int unsigned GROUPS = 3,
    parameter int unsigned BASE   = 10'h300
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [AW-1:0]        bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [DW-1:0]        bus_rdata,
    input logic                 div_en,
    input logic [GROUPS*DW-1:0] pix_mask
);

    localparam logic [AW-1:0] ON_A  = AW'(BASE + 26);
    localparam logic [AW-1:0] OFF_A = AW'(BASE + 25);
    localparam logic [AW-1:0] M0_A  = AW'(BASE + 2);

    // R6: set strobe raises the enable next cycle
    p_div_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ON_A |=> div_en);

    // R6: clear strobe lowers the enable next cycle
    p_div_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFF_A |=> !div_en);

    // R9: without a strobe write the enable keeps its value
    p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == ON_A || bus_addr == OFF_A)) |=> $stable(div_en));

    // R8: a read that is not on a data port answers 0xFF
    p_nondata_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr[1:0] != 2'b01 |=> bus_rdata == {DW{1'b1}});

    // R8: read data holds between read strobes
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R12: group 0 mask write appears on its output slice next cycle
    p_mask0_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == M0_A |=> pix_mask[DW-1:0] == $past(bus_wdata));

endmodule

bind pal_port_decoder palbus_checker #(
    .AW(AW), .DW(DW), .GROUPS(GROUPS), .BASE(BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .div_en(div_en), .pix_mask(pix_mask)
);

// File: tb/pal_port_decoder_test.sv
module pal_port_decoder_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        div_en;
    logic [23:0] pix_mask;
    logic [1:0]  lk_grp = '0;
    logic [7:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pal_port_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .div_en(div_en), .pix_mask(pix_mask),
        .lk_grp(lk_grp), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One-cycle write strobe; state is visible on return
    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // One-cycle read strobe; registered data sampled one cycle later
    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic look(input logic [1:0] g, input logic [7:0] i, output logic [23:0] c);
        lk_grp = g; lk_idx = i;
        #1;
        c = lk_rgb;
    endtask

    task automatic t_reset;
        logic [23:0] c;
        check("R1 div_en", {23'd0, div_en}, 24'd0);
        check("R1 masks", pix_mask, 24'd0);
        check("R1 rdata", {16'd0, bus_rdata}, 24'hFF);
        look(2'd0, 8'h00, c); check("R1 g0 entry", c, 24'd0);
        look(2'd2, 8'hFF, c); check("R1 g2 entry", c, 24'd0);
    endtask

    task automatic t_triplet;
        logic [23:0] c;
        wr(10'h302, 8'hFF);
        check("R12 g0 mask slice", pix_mask, 24'h0000FF);
        wr(10'h300, 8'h10);
        wr(10'h301, 8'h11); wr(10'h301, 8'h22); wr(10'h301, 8'h33);
        wr(10'h301, 8'h44); wr(10'h301, 8'h55); wr(10'h301, 8'h66);
        look(2'd0, 8'h10, c); check("R3 first triplet", c, 24'h112233);
        look(2'd0, 8'h11, c); check("R3 index advanced", c, 24'h445566);
        look(2'd0, 8'h12, c); check("R2 untouched entry", c, 24'h000000);
    endtask

    task automatic t_wrap;
        logic [23:0] c;
        wr(10'h300, 8'hFF);
        wr(10'h301, 8'h9A); wr(10'h301, 8'h9B); wr(10'h301, 8'h9C);
        wr(10'h301, 8'h01); wr(10'h301, 8'h02); wr(10'h301, 8'h03);
        look(2'd0, 8'hFF, c); check("R4 entry 255", c, 24'h9A9B9C);
        look(2'd0, 8'h00, c); check("R4 wrapped to 0", c, 24'h010203);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        logic [7:0] wexp [4] = '{8'h9A, 8'h9B, 8'h9C, 8'h01};
        wr(10'h303, 8'h10);
        for (int k = 0; k < 6; k++) begin
            rd(10'h301, d); check($sformatf("R7 read byte %0d", k), {16'd0, d}, {16'd0, exp[k]});
        end
        wr(10'h303, 8'hFF);
        for (int k = 0; k < 4; k++) begin
            rd(10'h301, d); check($sformatf("R7 wrap read %0d", k), {16'd0, d}, {16'd0, wexp[k]});
        end
    endtask

    task automatic t_reload;
        logic [23:0] c;
        logic [7:0] d;
        wr(10'h300, 8'h20);
        wr(10'h301, 8'hD1); wr(10'h301, 8'hD2);
        wr(10'h300, 8'h20);
        wr(10'h301, 8'hA7); wr(10'h301, 8'hB7); wr(10'h301, 8'hC7);
        look(2'd0, 8'h20, c); check("R5 write restart", c, 24'hA7B7C7);
        look(2'd0, 8'h21, c); check("R5 no spill", c, 24'h000000);
        wr(10'h303, 8'h20);
        rd(10'h301, d); rd(10'h301, d);
        wr(10'h303, 8'h20);
        rd(10'h301, d); check("R5 read restart", {16'd0, d}, 24'h0000A7);
    endtask

    task automatic t_div;
        wr(10'h31A, 8'h00); check("R6 set", {23'd0, div_en}, 24'd1);
        wr(10'h31A, 8'h55); check("R6 set again", {23'd0, div_en}, 24'd1);
        wr(10'h319, 8'hFF); check("R6 clear", {23'd0, div_en}, 24'd0);
        wr(10'h319, 8'h00); check("R6 clear again", {23'd0, div_en}, 24'd0);
    endtask

    task automatic t_ff;
        logic [7:0] d;
        logic [9:0] al [6] = '{10'h300, 10'h302, 10'h303, 10'h319, 10'h31A, 10'h305};
        for (int k = 0; k < 6; k++) begin
            rd(al[k], d);
            check($sformatf("R8 read 0x%0h", al[k]), {16'd0, d}, 24'hFF);
        end
        rd(10'h2FF, d); check("R8 outside window", {16'd0, d}, 24'hFF);
    endtask

    task automatic t_mask_lookup;
        logic [23:0] c;
        wr(10'h30A, 8'hFF);
        wr(10'h308, 8'h05);
        wr(10'h309, 8'hA1); wr(10'h309, 8'hA2); wr(10'h309, 8'hA3);
        wr(10'h30A, 8'h0F);
        check("R12 g1 mask slice", pix_mask, 24'h000FFF);
        look(2'd1, 8'h35, c); check("R10 masked index", c, 24'hA1A2A3);
        look(2'd3, 8'h05, c); check("R10 bad group", c, 24'h000000);
    endtask

    task automatic t_groups;
        logic [23:0] c;
        wr(10'h312, 8'hFF);
        wr(10'h310, 8'h10);
        wr(10'h311, 8'hC1); wr(10'h311, 8'hC2); wr(10'h311, 8'hC3);
        look(2'd2, 8'h10, c); check("R11 g2 entry", c, 24'hC1C2C3);
        look(2'd0, 8'h10, c); check("R11 g0 unchanged", c, 24'h112233);
        look(2'd1, 8'h05, c); check("R11 g1 unchanged", c, 24'hA1A2A3);
    endtask

    task automatic t_ignored;
        logic [23:0] c;
        wr(10'h31A, 8'h00);
        wr(10'h300, 8'h40);
        wr(10'h305, 8'h77); wr(10'h30C, 8'h77); wr(10'h314, 8'h77);
        wr(10'h318, 8'h77); wr(10'h31B, 8'h77); wr(10'h2FA, 8'h77);
        wr(10'h301, 8'hE1); wr(10'h301, 8'hE2); wr(10'h301, 8'hE3);
        look(2'd0, 8'h40, c); check("R9 gap writes ignored", c, 24'hE1E2E3);
        look(2'd0, 8'h41, c); check("R9 no stray entry", c, 24'h000000);
        check("R9 masks kept", pix_mask, 24'hFF0FFF);
        check("R9 div kept", {23'd0, div_en}, 24'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_triplet();
        t_wrap();
        t_readback();
        t_reload();
        t_div();
        t_ff();
        t_mask_lookup();
        t_groups();
        t_ignored();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule